// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital side of an 8-bit successive-approximation converter. It has a control register on a small bus port. Each write to that register picks a channel, picks one-pass or repeating operation, picks one-channel or four-channel scan, and starts a new sequence of four conversions. All timing advances only on a clock-enable tick. During each conversion the block raises a sample enable and drives the channel select. It then presents trial codes to an external DAC and reads back a one-bit comparator decision.

Each conversion lasts 32 ticks:

| Ticks | Phase |
|---|---|
| 12 | Sampling |
| 4 | Most significant bit decision |
| 2 each | Each of the seven lower bits |
| 2 | Closing phase, in which the result is stored |

Four result registers hold the outcomes. A completion flag goes high once the fourth conversion of a sequence has finished. Software polls the flag and reads the results through the same bus port. Reads return their data one clock after the request and never stall.

Top module: `sar_seq_top`

## Requirements
- R1: After a sequence, result register k (bus address k, k = 1..4) holds the code of the k-th conversion. For a static input, that code is the 8-bit value that the comparator model resolves, which is the input value itself.
- R2: Each conversion spans exactly 32 ticks. `sampleEn` is high during the first 12 ticks of every conversion and low otherwise. Conversion one begins with the first tick after a control write.
- R3: The first trial code of a conversion is 0x80, and it is held for 4 ticks. Each lower bit b then gets a 2-tick slot with the trial code equal to (decided upper bits) | (1<<b). A bit is cleared when `cmpBelow` is 1 on the last tick of its slot.
- R4: A result register changes only on tick 30 of its own conversion (ticks numbered 0..31), at the start of the 2-tick closing phase.
- R5: `doneFlag` rises only after tick 31 of the fourth conversion. Bit 0 at bus address 5 reads the same flag. The flag stays set until the next control write or reset.
- R6: When control bit 4 is 0, the block goes idle after one sequence (`sampleEn` stays low). When it is 1, conversion one restarts right after the fourth conversion, and this repeats indefinitely.
- R7: Control bits [2:0] hold the channel field and bit 3 selects scan. With bit 3 = 0, all four conversions use the channel in bits [2:0]. With bit 3 = 1, conversion k uses channel {bit 2, k-1}.
- R8: A bus write to address 0 stores all 8 bits, aborts any sequence in progress, clears `doneFlag`, and restarts at conversion one. Address 0 reads back the stored byte.
- R9: A read request returns data on `busRdData` one clock later. A read of a result register in the same clock as its update returns the old value.
- R10: On clocks with `tick` low and no control write, the sequence position, `sampleEn`, `dacCode` and the results do not change.
- R11: A synchronous reset makes the block idle, with the flag low, the control register, the results and `busRdData` all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Clock-enable that advances the sequence timing |
| busWrEn | input | 1 | Bus write strobe |
| busRdEn | input | 1 | Bus read strobe |
| busAddr | input | 3 | Bus address: 0 control, 1..4 results, 5 status |
| busWrData | input | 8 | Bus write data |
| busRdData | output | 8 | Registered bus read data |
| cmpBelow | input | 1 | Comparator: analog input is below the DAC output |
| chanSel | output | 3 | Analog channel select |
| sampleEn | output | 1 | Sample phase enable |
| dacCode | output | 8 | Trial code for the DAC |
| doneFlag | output | 1 | Sequence completion flag |

## Verification
The hardest cases are those where bus traffic and tick timing meet inside a sequence. These are a result read in the very clock its register is overwritten, and a control write that lands in the middle of a bit slot of a repeating sequence. To reach the first case, the stimulus issues back-to-back reads cycling over all four result addresses throughout a continuous sequence that follows a run with different input values. The old and new values therefore differ at the collision. To reach the second case, the bench holds `tick` low for a long stretch mid-slot and rewrites the control register while a continuous run is active. Irregular and random tick patterns shift every phase boundary relative to the bus activity.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  localparam int RES_BITS   = 8;
  localparam int NUM_CONV   = 4;
  localparam int CH_W       = 3;
  localparam int ADDR_W     = 3;
  localparam int SAMPLE_CYC = 12;
  localparam int MSB_CYC    = 4;
  localparam int BIT_CYC    = 2;
  localparam int END_CYC    = 2;

  localparam int FIRST_BIT  = SAMPLE_CYC + MSB_CYC;
  localparam int END_START  = FIRST_BIT + BIT_CYC * (RES_BITS - 1);
  localparam int CONV_CYC   = END_START + END_CYC;
  localparam int CNT_W      = $clog2(CONV_CYC);
  localparam int IDX_W      = $clog2(RES_BITS);
  localparam int CONV_W     = $clog2(NUM_CONV);
  localparam int MULTI_BIT  = CH_W;
  localparam int CONT_BIT   = CH_W + 1;
  localparam int STAT_ADDR  = NUM_CONV + 1;

  typedef struct packed {
    logic              restart;
    logic              loadMsb;
    logic              decide;
    logic [IDX_W-1:0]  bitIdx;
    logic              writeRes;
    logic [CONV_W-1:0] resIdx;
    logic              setFlag;
  } seqStrobe_t;
endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                ctrlWr,
  input  logic [RES_BITS-1:0] ctrlWrData,
  output logic [RES_BITS-1:0] ctrlReg,
  output logic [CH_W-1:0]     chanSel,
  output logic                sampleEn,
  output seqStrobe_t          str
);
  logic [CNT_W-1:0]  cycCnt;
  logic [CONV_W-1:0] convIdx;
  logic              active;
  logic              lastCyc;
  logic              lastConv;
  logic              stepEn;
  int                offs;

  assign stepEn   = tick && active && !ctrlWr;
  assign lastCyc  = (cycCnt == CNT_W'(CONV_CYC - 1));
  assign lastConv = (convIdx == CONV_W'(NUM_CONV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlReg <= '0;
      cycCnt  <= '0;
      convIdx <= '0;
      active  <= 1'b0;
    end else if (ctrlWr) begin
      ctrlReg <= ctrlWrData;
      cycCnt  <= '0;
      convIdx <= '0;
      active  <= 1'b1;
    end else if (stepEn) begin
      if (lastCyc) begin
        cycCnt <= '0;
        if (lastConv) begin
          convIdx <= '0;
          if (!ctrlReg[CONT_BIT]) active <= 1'b0;
        end else begin
          convIdx <= convIdx + CONV_W'(1);
        end
      end else begin
        cycCnt <= cycCnt + CNT_W'(1);
      end
    end
  end

  always_comb begin
    str = '0;
    offs = 0;
    str.restart = ctrlWr;
    if (stepEn) begin
      str.loadMsb = (cycCnt == CNT_W'(SAMPLE_CYC - 1));
      if (cycCnt == CNT_W'(FIRST_BIT - 1)) begin
        str.decide = 1'b1;
        str.bitIdx = IDX_W'(RES_BITS - 1);
      end else if (int'(cycCnt) >= FIRST_BIT && int'(cycCnt) < END_START) begin
        offs = int'(cycCnt) - FIRST_BIT;
        if (offs % BIT_CYC == BIT_CYC - 1) begin
          str.decide = 1'b1;
          str.bitIdx = IDX_W'(RES_BITS - 2 - offs / BIT_CYC);
        end
      end
      str.writeRes = (cycCnt == CNT_W'(END_START));
      str.resIdx   = convIdx;
      str.setFlag  = lastCyc && lastConv;
    end
  end

  assign sampleEn = active && (int'(cycCnt) < SAMPLE_CYC);

  generate
    if (CH_W > CONV_W) begin : g_grp
      assign chanSel = ctrlReg[MULTI_BIT] ? {ctrlReg[CH_W-1:CONV_W], convIdx}
                                          : ctrlReg[CH_W-1:0];
    end else begin : g_flat
      assign chanSel = ctrlReg[MULTI_BIT] ? CH_W'(convIdx) : ctrlReg[CH_W-1:0];
    end
  endgenerate

  // R10
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !ctrlWr) |=> ($stable(cycCnt) && $stable(convIdx) && $stable(active)));

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    ctrlWr |=> (active && cycCnt == '0 && convIdx == '0));

  // R6
  single_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (stepEn && lastCyc && lastConv && !ctrlReg[CONT_BIT]) |=> !active);

  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({str.loadMsb, str.decide, str.writeRes, str.setFlag}));
endmodule

// File: rtl/sar_seq_dp.sv
module sar_seq_dp
  import sar_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  seqStrobe_t          str,
  input  logic                cmpBelow,
  input  logic                busRdEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [RES_BITS-1:0] ctrlReg,
  output logic [RES_BITS-1:0] dacCode,
  output logic [RES_BITS-1:0] busRdData,
  output logic                doneFlag
);
  localparam logic [RES_BITS-1:0] MSB_ONE = RES_BITS'(1) << (RES_BITS - 1);

  logic [RES_BITS-1:0] sarReg;
  logic [RES_BITS-1:0] sarNext;
  logic [RES_BITS-1:0] resReg [NUM_CONV];
  logic [RES_BITS-1:0] rdMux;

  always_comb begin
    sarNext = sarReg;
    if (str.loadMsb) begin
      sarNext = MSB_ONE;
    end else if (str.decide) begin
      if (cmpBelow) sarNext[str.bitIdx] = 1'b0;
      if (str.bitIdx != '0) sarNext[str.bitIdx - IDX_W'(1)] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sarReg <= '0;
    else     sarReg <= sarNext;
  end

  assign dacCode = sarReg;

  generate
    for (genvar g = 0; g < NUM_CONV; g++) begin : g_res
      always_ff @(posedge clk) begin
        if (rst) resReg[g] <= '0;
        else if (str.writeRes && str.resIdx == CONV_W'(g)) resReg[g] <= sarReg;
      end

      // R4
      res_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(str.writeRes && str.resIdx == CONV_W'(g)) |=> $stable(resReg[g]));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)              doneFlag <= 1'b0;
    else if (str.restart) doneFlag <= 1'b0;
    else if (str.setFlag) doneFlag <= 1'b1;
  end

  always_comb begin
    rdMux = '0;
    if (busAddr == '0) begin
      rdMux = ctrlReg;
    end else if (busAddr == ADDR_W'(STAT_ADDR)) begin
      rdMux[0] = doneFlag;
    end else if (busAddr <= ADDR_W'(NUM_CONV)) begin
      rdMux = resReg[CONV_W'(busAddr - ADDR_W'(1))];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          busRdData <= '0;
    else if (busRdEn) busRdData <= rdMux;
  end

  // R5
  flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(doneFlag) |-> $past(str.setFlag));

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    str.restart |=> !doneFlag);

  // R3
  msb_trial_chk: assert property (@(posedge clk) disable iff (rst)
    str.loadMsb |=> (dacCode == MSB_ONE));
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
  import sar_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                busWrEn,
  input  logic                busRdEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [RES_BITS-1:0] busWrData,
  output logic [RES_BITS-1:0] busRdData,
  input  logic                cmpBelow,
  output logic [CH_W-1:0]     chanSel,
  output logic                sampleEn,
  output logic [RES_BITS-1:0] dacCode,
  output logic                doneFlag
);
  seqStrobe_t          str;
  logic [RES_BITS-1:0] ctrlReg;
  logic                ctrlWr;

  assign ctrlWr = busWrEn && (busAddr == '0);

  sar_seq_ctrl i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .ctrlWr     (ctrlWr),
    .ctrlWrData (busWrData),
    .ctrlReg    (ctrlReg),
    .chanSel    (chanSel),
    .sampleEn   (sampleEn),
    .str        (str)
  );

  sar_seq_dp i_dp (
    .clk       (clk),
    .rst       (rst),
    .str       (str),
    .cmpBelow  (cmpBelow),
    .busRdEn   (busRdEn),
    .busAddr   (busAddr),
    .ctrlReg   (ctrlReg),
    .dacCode   (dacCode),
    .busRdData (busRdData),
    .doneFlag  (doneFlag)
  );
endmodule

// File: tb/test_sar_seq_top.sv
`timescale 1ns/1ps
module test_sar_seq_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       busWrEn = 1'b0;
  logic       busRdEn = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       cmpBelow;
  logic [2:0] chanSel;
  logic       sampleEn;
  logic [7:0] dacCode;
  logic       doneFlag;

  logic [7:0] ana [8];
  assign cmpBelow = (ana[chanSel] < dacCode);

  sar_seq_top i_sar_seq_top (
    .clk(clk), .rst(rst), .tick(tick), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .cmpBelow(cmpBelow), .chanSel(chanSel), .sampleEn(sampleEn),
    .dacCode(dacCode), .doneFlag(doneFlag)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int tickMode = 0;
  int tickCnt = 0;

  // behavioural reference state
  int         mPos = 0;
  bit         mActive = 0;
  bit         mFlag = 0;
  logic [7:0] mCtrl = '0;
  logic [7:0] mRes [4] = '{default: 8'h00};
  logic [7:0] mRd = '0;
  bit         mRdValid = 0;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] chanOf(int k);
    return mCtrl[3] ? {mCtrl[2], 2'(k)} : mCtrl[2:0];
  endfunction

  function automatic logic [7:0] readModel(logic [2:0] a);
    if (a == 0) return mCtrl;
    if (a == 5) return {7'b0, mFlag};
    if (a >= 1 && a <= 4) return mRes[a-1];
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mActive = 0; mFlag = 0; mCtrl = '0; mPos = 0; mRdValid = 0;
      for (int i = 0; i < 4; i++) mRes[i] = '0;
    end else begin
      mRdValid = busRdEn;
      if (busRdEn) mRd = readModel(busAddr);
      if (busWrEn && busAddr == 0) begin
        mCtrl = busWrData; mActive = 1; mPos = 0; mFlag = 0;
      end else if (tick && mActive) begin
        if (mPos % 32 == 30) mRes[mPos/32] = ana[chanOf(mPos/32)];
        if (mPos == 127) begin
          mFlag = 1;
          if (mCtrl[4]) mPos = 0; else mActive = 0;
        end else mPos++;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      int c;
      c = mPos % 32;
      check(sampleEn == (mActive && c < 12), "R2 sampleEn", sampleEn, mActive && c < 12);
      check(doneFlag == mFlag, "R5 doneFlag", doneFlag, mFlag);
      if (mActive) begin
        check(chanSel == chanOf(mPos/32), "R7 chanSel", chanSel, chanOf(mPos/32));
        if (c >= 12 && c < 30) begin
          int b;
          logic [7:0] v, e;
          b = (c < 16) ? 7 : 6 - (c - 16) / 2;
          v = ana[chanOf(mPos/32)];
          e = (v & ~8'((16'h1 << (b + 1)) - 1)) | 8'(1 << b);
          check(dacCode == e, "R3 dacCode", dacCode, e);
        end
      end
      if (mRdValid)
        check(busRdData == mRd, "R1/R4/R9 busRdData", busRdData, mRd);
    end
  end

  task automatic drvTick();
    case (tickMode)
      0: tick = 1'b1;
      1: tick = (tickCnt % 3 == 0);
      2: tick = 1'($urandom % 2);
      default: tick = 1'b0;
    endcase
    tickCnt++;
  endtask

  task automatic step();
    @(posedge clk); #1;
    drvTick();
    busWrEn = 0; busRdEn = 0;
  endtask

  task automatic wrCtrl(logic [7:0] v);
    @(posedge clk); #1;
    drvTick();
    busWrEn = 1; busRdEn = 0; busAddr = 3'd0; busWrData = v;
  endtask

  task automatic rdReq(logic [2:0] a);
    @(posedge clk); #1;
    drvTick();
    busWrEn = 0; busRdEn = 1; busAddr = a;
  endtask

  task automatic rdChk(logic [2:0] a, logic [7:0] exp, string req);
    rdReq(a);
    step();
    check(busRdData == exp, req, busRdData, exp);
  endtask

  task automatic waitDone(string req);
    for (int i = 0; i < 3000 && !(mFlag && !busWrEn); i++) step();
    step();
    check(doneFlag == 1'b1, req, doneFlag, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    ana = '{8'h00, 8'h37, 8'hA5, 8'h7F, 8'h80, 8'h01, 8'hFE, 8'hFF};
    repeat (3) step();
    @(posedge clk); #1; rst = 0;
    step();
    // R11 reset state
    check(doneFlag == 0, "R11 flag after reset", doneFlag, 0);
    check(sampleEn == 0, "R11 idle after reset", sampleEn, 0);
    check(busRdData == 0, "R11 read data after reset", busRdData, 0);
    rdChk(3'd0, 8'h00, "R11 control after reset");
    rdChk(3'd2, 8'h00, "R11 result after reset");

    // single pass, single channel 5, tick every clock
    tickMode = 0;
    wrCtrl(8'h05);
    waitDone("R5 single-channel pass done");
    for (int k = 1; k <= 4; k++) rdChk(3'(k), ana[5], "R1 single-channel result");
    rdChk(3'd5, 8'h01, "R5 status read");
    repeat (40) step();
    check(sampleEn == 0, "R6 idle after one pass", sampleEn, 0);
    rdChk(3'd0, 8'h05, "R8 control readback");

    // single pass, scan group 1 (channels 4..7), sparse ticks
    ana[4] = 8'h5A; ana[5] = 8'hC3; ana[6] = 8'h10; ana[7] = 8'hEF;
    tickMode = 1;
    wrCtrl(8'h0C);
    step();
    check(doneFlag == 0, "R8 flag cleared by write", doneFlag, 0);
    waitDone("R5 scan pass done");
    for (int k = 1; k <= 4; k++) rdChk(3'(k), ana[3 + k], "R7 scan result order");

    // continuous scan group 0, random ticks, reads every clock
    ana[0] = 8'h00; ana[1] = 8'hFF; ana[2] = 8'h81; ana[3] = 8'h3C;
    tickMode = 2;
    wrCtrl(8'h18);
    for (int i = 0; i < 300; i++) rdReq(3'(1 + i % 4));
    waitDone("R5 continuous first pass");
    begin
      int seen = 0;
      for (int i = 0; i < 200; i++) begin
        step();
        if (sampleEn) seen++;
      end
      check(seen > 0, "R6 continuous restarts", seen, 1);
      check(doneFlag == 1, "R5 flag held in continuous", doneFlag, 1);
    end

    // abort mid-slot, then stall ticks
    tickMode = 0;
    wrCtrl(8'h02);
    step();
    check(doneFlag == 0, "R8 abort clears flag", doneFlag, 0);
    repeat (19) step();
    tickMode = 3;
    step();
    begin
      logic [7:0] d0;
      logic       s0;
      d0 = dacCode; s0 = sampleEn;
      repeat (50) step();
      check(dacCode == d0, "R10 dacCode frozen", dacCode, d0);
      check(sampleEn == s0, "R10 sampleEn frozen", sampleEn, s0);
    end
    tickMode = 0;
    waitDone("R8 restarted pass completes");
    for (int k = 1; k <= 4; k++) rdChk(3'(k), ana[2], "R1 result after abort");

    // reset mid-run
    wrCtrl(8'h1B);
    repeat (70) step();
    @(posedge clk); #1; rst = 1;
    step();
    @(posedge clk); #1; rst = 0;
    step();
    check(doneFlag == 0, "R11 flag after mid-run reset", doneFlag, 0);
    check(sampleEn == 0, "R11 idle after mid-run reset", sampleEn, 0);
    rdChk(3'd1, 8'h00, "R11 results cleared");
    rdChk(3'd0, 8'h00, "R11 control cleared");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule